// File: doc/BRIEF.md
# BIP-8 Section and Line Parity Monitor

The block watches a byte-wide frame stream and keeps two bit-interleaved even parity sums per frame. One covers every byte of the frame (section parity). The other skips the section overhead corner (line parity). When a new frame starts, the sums of the frame that just ended become the recalculated parity bytes. Downstream logic can insert these bytes into outgoing data. In the next frame, the received section and line parity bytes are compared bit by bit with these values. Each mismatching bit adds one to that parity's error counter.

A mode input selects how the section parity byte is read. In single-channel mode the byte holds parity and is compared with the recalculated value. In multiplexed mode the byte holds one error flag per bit. Its set bits are counted directly and no comparison is made. The line parity byte is always compared.

Software-facing logic reads the counts through a snapshot strobe. In one cycle the strobe copies both live counts to output registers and restarts the live counts, so no error is lost. A three-state controller tracks how much history exists:

- IDLE: no frame start has been seen. Bytes are ignored.
- FIRST: one frame is in progress and no previous parity exists.
- RUN: comparisons are active.

There are two transitions. LOCK moves IDLE to FIRST on the first frame-start byte. ARM moves FIRST to RUN on the next frame-start byte. RUN holds until reset.

Top module: `bip_parity_monitor`

## Requirements
- R1: After reset, `snap_done`, both snapshot counts, `b1_calc` and `b2_calc` are all zero.
- R2: A byte counts only when `in_vld` is 1. A counted byte with `in_sof` = 1 sits at row 0, column 0. Later counted bytes fill rows of COLS columns, and ROWS rows make a frame. `in_sof` without `in_vld` has no effect. Bytes before the first frame start change no output.
- R3: On the frame-start byte of every frame after the first, `b1_calc` takes the XOR of all counted bytes of the frame that ended. `b2_calc` takes the XOR of those bytes, leaving out rows below SOH_ROWS that are also in columns below TOH_COLS. Both bytes are visible after that clock edge and hold until the next frame start.
- R4: With `mode_stsn` = 0 in state RUN, the byte at row B1_ROW, column 0 adds the number of ones in (byte XOR `b1_calc`) to the live section count.
- R5: With `mode_stsn` = 1, the byte at row B1_ROW, column 0 adds its own number of ones to the live section count. This happens in state FIRST as well as in RUN.
- R6: In state RUN, in either mode, the byte at row B2_ROW, column 0 adds the number of ones in (byte XOR `b2_calc`) to the live line count.
- R7: During the first frame after reset (state FIRST), no line comparison is made. No section comparison is made in mode 0.
- R8: When `snap_req` is sampled as 1, `snap_done` is 1 in the next cycle only. The snapshot outputs then show the live counts from before that cycle's increment. The live counts restart from that cycle's increment.
- R9: A live count stops at 2^CNT_W-1 and does not wrap.
- R10: The snapshot outputs do not change except in the cycle after a sampled `snap_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_stsn | input | 1 | 0: section byte holds parity; 1: section byte holds error flags |
| in_vld | input | 1 | Byte valid |
| in_sof | input | 1 | Marks the first byte of a frame (meaningful with in_vld) |
| in_byte | input | 8 | Received byte |
| snap_req | input | 1 | Copy live counts to snapshot outputs and restart them |
| snap_done | output | 1 | One-cycle pulse after a sampled snap_req |
| snap_b1_errs | output | CNT_W | Section error count at the last snapshot |
| snap_b2_errs | output | CNT_W | Line error count at the last snapshot |
| b1_calc | output | 8 | Recalculated section parity of the last complete frame |
| b2_calc | output | 8 | Recalculated line parity of the last complete frame |

## Verification
The bench builds the block with a 9-row by 4-column frame. This keeps the section corner at three rows by three columns and leaves one column outside it. Each frame is then 36 bytes, so many frames with exact parity fit into a short run. CNT_W is set to 6, which lets nine frames of eight errors each reach the saturation limit of 63. The short frame also allows a snapshot to be placed on the exact cycle of a parity byte, and a reset in the middle of a run to bring back the first-frame rules.

// File: rtl/bip_mon_pkg.sv
package bip_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2
    } mon_state_e;

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/bip_pos_tracker.sv
module bip_pos_tracker #(
    parameter int ROWS = 9,
    parameter int COLS = 90,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          sof,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);
    localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] C_LAST = CW'(COLS - 1);

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;

    always_comb begin
        cur_row = sof ? '0 : row_q;
        cur_col = sof ? '0 : col_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (adv) begin
            if (cur_col == C_LAST) begin
                col_q <= '0;
                row_q <= (cur_row == R_LAST) ? '0 : cur_row + 1'b1;
            end else begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
        end
    end

endmodule

// File: rtl/bip_parity_acc.sv
module bip_parity_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       sof,
    input  logic       incl,
    input  logic [7:0] din,
    output logic [7:0] acc_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (adv) begin
            if (sof) begin
                acc_q <= incl ? din : 8'd0;
            end else if (incl) begin
                acc_q <= acc_q ^ din;
            end
        end
    end

endmodule

// File: rtl/bip_err_counter.sv
module bip_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       inc,
    input  logic             snap,
    output logic [CNT_W-1:0] live_q,
    output logic [CNT_W-1:0] snap_q
);
    localparam logic [CNT_W:0] SAT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, live_q} + (CNT_W+1)'(inc);
        if (sum > SAT) begin
            sum = SAT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            snap_q <= '0;
        end else if (snap) begin
            snap_q <= live_q;
            live_q <= CNT_W'(inc);
        end else begin
            live_q <= sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/bip_parity_monitor.sv
module bip_parity_monitor
    import bip_mon_pkg::*;
#(
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int SOH_ROWS = 3,
    parameter int TOH_COLS = 3,
    parameter int B1_ROW   = 1,
    parameter int B2_ROW   = 4,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_stsn,
    input  logic             in_vld,
    input  logic             in_sof,
    input  logic [7:0]       in_byte,
    input  logic             snap_req,
    output logic             snap_done,
    output logic [CNT_W-1:0] snap_b1_errs,
    output logic [CNT_W-1:0] snap_b2_errs,
    output logic [7:0]       b1_calc,
    output logic [7:0]       b2_calc
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int NSUM = 2;
    localparam logic [RW-1:0] B1_R  = RW'(B1_ROW);
    localparam logic [RW-1:0] B2_R  = RW'(B2_ROW);
    localparam logic [RW-1:0] SOH_R = RW'(SOH_ROWS);
    localparam logic [CW-1:0] TOH_C = CW'(TOH_COLS);

    mon_state_e st_q, st_d;

    logic          trk;
    logic          sof_trk;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic          in_line_zone;
    logic          at_b1, at_b2;

    logic [7:0]       acc   [NSUM];
    logic             incl  [NSUM];
    logic [3:0]       inc   [NSUM];
    logic [CNT_W-1:0] live  [NSUM];
    logic [CNT_W-1:0] snapv [NSUM];

    logic [7:0] b1_calc_q, b2_calc_q;
    logic       snap_done_q;
    logic [CNT_W-1:0] b1_live, b2_live;
    logic [3:0]       b2_inc;

    // A byte is tracked once framing is known, or when it starts a frame.
    assign trk     = in_vld & (in_sof | (st_q != ST_IDLE));
    assign sof_trk = in_vld & in_sof;

    bip_pos_tracker #(
        .ROWS(ROWS),
        .COLS(COLS)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (trk),
        .sof    (sof_trk),
        .cur_row(cur_row),
        .cur_col(cur_col)
    );

    assign in_line_zone = !((cur_row < SOH_R) && (cur_col < TOH_C));
    assign at_b1 = trk & ~in_sof & (cur_row == B1_R) & (cur_col == '0);
    assign at_b2 = trk & ~in_sof & (cur_row == B2_R) & (cur_col == '0);

    assign incl[0] = 1'b1;
    assign incl[1] = in_line_zone;

    // Two parity sums and two error counters share one structure each.
    for (genvar g = 0; g < NSUM; g++) begin : g_sum
        bip_parity_acc u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .adv  (trk),
            .sof  (sof_trk),
            .incl (incl[g]),
            .din  (in_byte),
            .acc_q(acc[g])
        );

        bip_err_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .snap  (snap_req),
            .live_q(live[g]),
            .snap_q(snapv[g])
        );
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and per-byte error increments.
    always_comb begin
        st_d   = st_q;
        inc[0] = 4'd0;
        inc[1] = 4'd0;
        unique case (st_q)
            ST_IDLE: begin
                if (sof_trk) begin
                    st_d = ST_FIRST;          // LOCK
                end
            end
            ST_FIRST: begin
                if (at_b1 && mode_stsn) begin
                    inc[0] = ones8(in_byte);
                end
                if (sof_trk) begin
                    st_d = ST_RUN;            // ARM
                end
            end
            ST_RUN: begin
                if (at_b1) begin
                    inc[0] = mode_stsn ? ones8(in_byte)
                                       : ones8(in_byte ^ b1_calc_q);
                end
                if (at_b2) begin
                    inc[1] = ones8(in_byte ^ b2_calc_q);
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // Frame close: the sums of the finished frame become the recalculated bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b1_calc_q   <= '0;
            b2_calc_q   <= '0;
            snap_done_q <= 1'b0;
        end else begin
            snap_done_q <= snap_req;
            if (sof_trk && (st_q != ST_IDLE)) begin
                b1_calc_q <= acc[0];
                b2_calc_q <= acc[1];
            end
        end
    end

    assign b1_live      = live[0];
    assign b2_live      = live[1];
    assign b2_inc       = inc[1];
    assign snap_done    = snap_done_q;
    assign snap_b1_errs = snapv[0];
    assign snap_b2_errs = snapv[1];
    assign b1_calc      = b1_calc_q;
    assign b2_calc      = b2_calc_q;

endmodule

// File: rtl/bip_parity_monitor_chk.sv
module bip_parity_monitor_chk
    import bip_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snap_req,
    input logic             snap_done,
    input logic [CNT_W-1:0] snap_b1_errs,
    input logic [CNT_W-1:0] snap_b2_errs,
    input logic [7:0]       b1_calc,
    input logic [7:0]       b2_calc,
    input logic             in_vld,
    input logic             in_sof,
    input mon_state_e       st_q,
    input logic [CNT_W-1:0] b1_live,
    input logic [CNT_W-1:0] b2_live,
    input logic [3:0]       b2_inc
);
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> snap_done);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> !snap_done);

    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> ($stable(snap_b1_errs) && $stable(snap_b2_errs)));

    p_no_wrap_b1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> (b1_live >= $past(b1_live)));

    p_no_wrap_b2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> (b2_live >= $past(b2_live)));

    p_calc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_vld && in_sof) |=> ($stable(b1_calc) && $stable(b2_calc)));

    p_first_no_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |-> (b2_inc == 4'd0));

endmodule

bind bip_parity_monitor bip_parity_monitor_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snap_req    (snap_req),
    .snap_done   (snap_done),
    .snap_b1_errs(snap_b1_errs),
    .snap_b2_errs(snap_b2_errs),
    .b1_calc     (b1_calc),
    .b2_calc     (b2_calc),
    .in_vld      (in_vld),
    .in_sof      (in_sof),
    .st_q        (st_q),
    .b1_live     (b1_live),
    .b2_live     (b2_live),
    .b2_inc      (b2_inc)
);

// File: tb/tb_bip_parity_monitor.sv
`timescale 1ns/1ps
module tb_bip_parity_monitor;
    localparam int ROWS     = 9;
    localparam int COLS     = 4;
    localparam int SOH_ROWS = 3;
    localparam int TOH_COLS = 3;
    localparam int B1_ROW   = 1;
    localparam int B2_ROW   = 4;
    localparam int CNT_W    = 6;
    localparam int MAXC     = (1 << CNT_W) - 1;
    localparam int FLEN     = ROWS * COLS;
    localparam int B1_IDX   = B1_ROW * COLS;
    localparam int B2_IDX   = B2_ROW * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_stsn = 1'b0;
    logic in_vld = 1'b0;
    logic in_sof = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic snap_req = 1'b0;
    logic snap_done;
    logic [CNT_W-1:0] snap_b1_errs, snap_b2_errs;
    logic [7:0] b1_calc, b2_calc;

    always #2.5 clk = ~clk;

    bip_parity_monitor #(
        .ROWS(ROWS), .COLS(COLS), .SOH_ROWS(SOH_ROWS), .TOH_COLS(TOH_COLS),
        .B1_ROW(B1_ROW), .B2_ROW(B2_ROW), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_stsn(mode_stsn), .in_vld(in_vld),
        .in_sof(in_sof), .in_byte(in_byte), .snap_req(snap_req),
        .snap_done(snap_done), .snap_b1_errs(snap_b1_errs),
        .snap_b2_errs(snap_b2_errs), .b1_calc(b1_calc), .b2_calc(b2_calc)
    );

    typedef struct {
        int         e1;
        int         e2;
        logic [7:0] c1;
        logic [7:0] c2;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int last_e1 = 0;
    int last_e2 = 0;
    bit finished = 1'b0;

    // Bench model state, built from the requirements.
    int m_state = 0;
    int m_row = 0;
    int m_col = 0;
    logic [7:0] m_acc1 = 0, m_acc2 = 0, m_c1 = 0, m_c2 = 0;
    int m_live1 = 0, m_live2 = 0;

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_row = 0; m_col = 0;
        m_acc1 = 0; m_acc2 = 0; m_c1 = 0; m_c2 = 0;
        m_live1 = 0; m_live2 = 0;
        sb_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 0; in_sof = 0; snap_req = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: applies one cycle of stimulus and updates the model.
    task automatic drive(input logic [7:0] d, input bit v, input bit s, input bit sn,
                         input bit md, input string tag);
        int inc1 = 0, inc2 = 0, r, c;
        bit zone;
        @(negedge clk);
        in_byte = d; in_vld = v; in_sof = s; snap_req = sn; mode_stsn = md;
        if (v && (s || m_state != 0)) begin
            r = s ? 0 : m_row;
            c = s ? 0 : m_col;
            if (!s && c == 0 && r == B1_ROW) begin
                if (m_state == 2) inc1 = md ? pop8(d) : pop8(d ^ m_c1);
                else if (m_state == 1 && md) inc1 = pop8(d);
            end
            if (!s && c == 0 && r == B2_ROW && m_state == 2) inc2 = pop8(d ^ m_c2);
            if (s && m_state != 0) begin
                m_c1 = m_acc1; m_c2 = m_acc2;
            end
            zone = !(r < SOH_ROWS && c < TOH_COLS);
            if (s) begin
                m_acc1 = d;
                m_acc2 = zone ? d : 8'd0;
                m_state = (m_state == 0) ? 1 : 2;
            end else begin
                m_acc1 ^= d;
                if (zone) m_acc2 ^= d;
            end
            if (c == COLS - 1) begin
                m_col = 0;
                m_row = (r == ROWS - 1) ? 0 : r + 1;
            end else begin
                m_col = c + 1;
                m_row = r;
            end
        end
        if (sn) begin
            exp_t e;
            e.e1 = m_live1; e.e2 = m_live2; e.c1 = m_c1; e.c2 = m_c2; e.tag = tag;
            sb_q.push_back(e);
            m_live1 = inc1; m_live2 = inc2;
        end else begin
            m_live1 = (m_live1 + inc1 > MAXC) ? MAXC : m_live1 + inc1;
            m_live2 = (m_live2 + inc2 > MAXC) ? MAXC : m_live2 + inc2;
        end
    endtask

    task automatic idle(input bit md);
        drive(8'h5A, 1'b0, 1'b0, 1'b0, md, "");
    endtask

    task automatic snap_now(input bit md, input string tag);
        drive(8'h00, 1'b0, 1'b0, 1'b1, md, tag);
        idle(md);
        idle(md);
    endtask

    // One frame; masks set which parity bits are wrong (or, in mode 1, flagged).
    task automatic send_frame(input int seed, input logic [7:0] m1, input logic [7:0] m2,
                              input bit md, input int snap_idx, input string tag);
        for (int i = 0; i < FLEN; i++) begin
            logic [7:0] d;
            d = 8'(seed * 29 + i * 11 + i * i);
            if (i == B1_IDX) d = md ? m1 : (m_c1 ^ m1);
            if (i == B2_IDX) d = m_c2 ^ m2;
            if (i % 7 == 3) drive(8'hC3, 1'b0, 1'(i % 2), 1'b0, md, "");   // R2 bubble
            drive(d, 1'b1, (i == 0), (i == snap_idx), md, tag);
        end
    endtask

    // Monitor: pops the scoreboard whenever a snapshot is produced.
    always @(negedge clk) begin
        if (rst_n && snap_done && !finished) begin
            if (sb_q.size() == 0) begin
                check("R8", "unexpected snap_done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "section count", int'(snap_b1_errs), e.e1);
                check(e.tag, "line count",    int'(snap_b2_errs), e.e2);
                check(e.tag, "b1_calc",       int'(b1_calc),      int'(e.c1));
                check(e.tag, "b2_calc",       int'(b2_calc),      int'(e.c2));
                last_e1 = e.e1;
                last_e2 = e.e2;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset values at the ports
        check("R1", "snap_done", int'(snap_done), 0);
        check("R1", "section snap", int'(snap_b1_errs), 0);
        check("R1", "line snap", int'(snap_b2_errs), 0);
        check("R1", "b1_calc", int'(b1_calc), 0);
        check("R1", "b2_calc", int'(b2_calc), 0);

        // R2: bytes before any frame start change nothing
        for (int i = 0; i < 20; i++) drive(8'(i * 17 + 3), 1'b1, 1'b0, 1'b0, 1'b1, "");
        drive(8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, "");
        snap_now(1'b0, "R2");

        // R7: first frame, every parity wrong, nothing counted
        send_frame(1, 8'hFF, 8'hFF, 1'b0, -1, "");
        snap_now(1'b0, "R7");

        // R3/R4/R6: compared frame, 4 section and 1 line errors
        send_frame(2, 8'h0F, 8'h01, 1'b0, -1, "");
        snap_now(1'b0, "R3_R4_R6");

        // R3: clean frame
        send_frame(3, 8'h00, 8'h00, 1'b0, -1, "");
        snap_now(1'b0, "R3_clean");

        // R5: flag mode counts set bits of the section byte
        send_frame(4, 8'hA5, 8'h00, 1'b1, -1, "");
        snap_now(1'b1, "R5");

        // R8: snapshot on the section parity byte's own cycle
        send_frame(5, 8'h03, 8'h10, 1'b0, B1_IDX, "R8_collide");
        snap_now(1'b0, "R8_carry");

        // R10: counts move, snapshot outputs must not
        send_frame(6, 8'h77, 8'h0F, 1'b0, -1, "");
        check("R10", "section snap held", int'(snap_b1_errs), last_e1);
        check("R10", "line snap held", int'(snap_b2_errs), last_e2);
        snap_now(1'b0, "R10_release");

        // R9: nine frames of eight errors each saturate at MAXC
        for (int k = 0; k < 9; k++) send_frame(10 + k, 8'hFF, 8'hFF, 1'b1, -1, "");
        snap_now(1'b1, "R9");

        // R5/R7: after reset, flag mode counts in the first frame, line does not
        do_reset();
        send_frame(30, 8'h07, 8'hFF, 1'b1, -1, "");
        snap_now(1'b1, "R5_R7_first");

        repeat (5) idle(1'b0);
        check("R8", "pending snapshots", sb_q.size(), 0);
        finish_run();
    end

endmodule